// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer with Byte Lanes

This block sits between a synchronous host and an external asynchronous static RAM of 64K words by 16 bits. The host hands over one request at a time with a valid/ready handshake: a read or write flag, a word address, write data and a two-bit lane mask. The block then plays out the active-low pin sequence the memory needs. Chip select, write enable and output enable are driven, together with one enable per byte lane, and the address is held steady. Each phase lasts a whole number of clock cycles, and that number is derived from the memory's minimum timings.

The bidirectional data bus is split into a driven word, a drive enable and a sampled word. A read ends with the sampled word registered and handed back through a one-cycle valid pulse. Lanes the host did not select read back as zero. After every read the bus is kept quiet for a turnaround window, so that the memory's output buffers have let go before the controller may drive again.

Top module: `sram_ctl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows chip select, write enable, output enable and both lane enables high, `sram_dq_oe` low, `rd_valid` low and `req_ready` high.
- R2: An accepted write gives exactly WP cycles with `sram_cs_n` and `sram_we_n` low and `sram_oe_n` high, with `sram_dq_oe` high, `sram_dq_out` equal to the request data and `sram_addr` equal to the request address. WP is ceil(T_WP/CLK_NS), which is 3 by default.
- R3: The write pulse is followed by REC cycles with every strobe high and `sram_dq_oe` low, and `req_ready` low. REC is WC minus WP when that difference is positive and 1 otherwise, with WC = ceil(T_WC/CLK_NS). The default is 2.
- R4: During the strobe phase of either access, `sram_be_n[0]` (bits 7..0) is low exactly when mask bit 0 is set, and `sram_be_n[1]` (bits 15..8) is low exactly when mask bit 1 is set. A lane whose enable stays high is not written.
- R5: An accepted read gives ACC cycles with `sram_cs_n` and `sram_oe_n` low, `sram_we_n` high and `sram_dq_oe` low. ACC is the larger of ceil(T_RC/CLK_NS) and ceil(T_AA/CLK_NS), which is 5 by default.
- R6: In the cycle after the last read-access cycle, `rd_valid` is high for exactly one cycle. `rd_data` then holds `sram_dq_in` as sampled at the edge that ends the access, with unselected lanes forced to zero.
- R7: A read is followed by HZ = ceil(T_HZ/CLK_NS) cycles (2 by default) with every strobe high, `sram_dq_oe` low and `req_ready` low. The bus is never driven sooner than HZ cycles after output enable was low.
- R8: `req_ready` is high only while idle, and a request is taken at an edge where `req_valid` and `req_ready` are both high. Request inputs that change while busy do not affect the address, data or lanes of the access in progress.
- R9: A request presented during the first idle cycle after an access is accepted at the end of that cycle, so consecutive accesses are separated by exactly one idle cycle.
- R10: Every phase length is the matching timing divided by CLK_NS and rounded up, with a minimum of one cycle.
- R11: Pulling `rst_n` low in the middle of an access returns every pin to its idle level one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = low byte, bit 1 = high byte |
| req_ready | output | 1 | Controller idle and able to accept |
| rd_valid | output | 1 | One-cycle pulse carrying read data |
| rd_data | output | 16 | Captured read word, unselected lanes zero |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_be_n | output | 2 | Lane enables, active low, bit 1 = high byte |
| sram_addr | output | 16 | Memory address |
| sram_dq_out | output | 16 | Data driven toward memory |
| sram_dq_oe | output | 1 | Controller drives the data bus |
| sram_dq_in | input | 16 | Data sampled from memory |

## Verification
With default timings, a write accepted at edge E shows its pulse in cycles 1 to 3 after E and recovery in cycles 4 and 5, and `req_ready` comes back in cycle 6. A read accepted at E holds its strobes in cycles 1 to 5 and raises `rd_valid` in cycle 6, the first of two turnaround cycles, and is idle again in cycle 8. The bench counts these cycles from its own copies of the timing parameters, checks every pin on the falling edge of each cycle of a transaction, and takes expected read words from a shadow array that it updates from each request's mask. It also keeps a pin-driven memory model that returns distinctive junk on unselected lanes.

// File: rtl/sram_ctl_pkg.sv
// Shared types and helpers for the asynchronous SRAM sequencer.
// Assumes timing values and clock period are positive nanosecond integers.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WPULSE = 3'd1,
        PH_WREC   = 3'd2,
        PH_RACC   = 3'd3,
        PH_TURN   = 3'd4
    } phase_e;

    // Cycles needed to cover t_ns at clk_ns per cycle, never less than one.
    function automatic int cycles_for(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
// Phase down-counter. A load sets the length of the next phase; `last`
// is high in the final cycle of that phase. Assumes load values >= 1.
module sram_ctl_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt;

    // Count down toward one, reloading at each phase change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= CW'(1);
        else if (load)
            cnt <= load_val;
        else if (cnt > CW'(1))
            cnt <= cnt - CW'(1);
    end

    assign last = (cnt == CW'(1));

endmodule

// File: rtl/sram_ctl_seq.sv
// Access sequencer. Takes one host request while idle, holds its fields,
// and steps through pulse/recovery (write) or access/turnaround (read).
// Assumes the phase timer reports the final cycle of each loaded phase.
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int NB      = 2,
    parameter int CW      = 3,
    parameter int WP_CYC  = 3,
    parameter int REC_CYC = 2,
    parameter int ACC_CYC = 5,
    parameter int HZ_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [NB-1:0] req_mask,
    input  logic          phase_last,
    output phase_e        phase,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic [AW-1:0] lat_addr,
    output logic [DW-1:0] lat_wdata,
    output logic [NB-1:0] lat_mask
);

    phase_e nxt;
    logic   take;

    assign take = (phase == PH_IDLE) && req_valid;

    // Next phase and the length to load for it.
    always_comb begin
        nxt      = phase;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (phase)
            PH_IDLE: if (req_valid) begin
                nxt      = req_write ? PH_WPULSE : PH_RACC;
                tmr_load = 1'b1;
                tmr_val  = req_write ? CW'(WP_CYC) : CW'(ACC_CYC);
            end
            PH_WPULSE: if (phase_last) begin
                nxt      = PH_WREC;
                tmr_load = 1'b1;
                tmr_val  = CW'(REC_CYC);
            end
            PH_WREC: if (phase_last) nxt = PH_IDLE;
            PH_RACC: if (phase_last) begin
                nxt      = PH_TURN;
                tmr_load = 1'b1;
                tmr_val  = CW'(HZ_CYC);
            end
            PH_TURN: if (phase_last) nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= nxt;
    end

    // Hold request fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_mask  <= '0;
        end else if (take) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_mask  <= req_mask;
        end
    end

endmodule

// File: rtl/sram_ctl_capture.sv
// Read capture. Registers the sampled bus word with unselected lanes
// cleared and raises a one-cycle valid. Assumes DW = 8 * NB.
module sram_ctl_capture #(
    parameter int DW = 16,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [NB-1:0] mask,
    input  logic [DW-1:0] data_in,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] lane_data;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign lane_data[i*8 +: 8] = mask[i] ? data_in[i*8 +: 8] : 8'h00;
    end

    // Capture word and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= cap_en;
            if (cap_en) rd_data <= lane_data;
        end
    end

endmodule

// File: rtl/sram_ctl.sv
// Top of the asynchronous SRAM sequencer. Converts single host requests
// into active-low pin phases whose lengths come from timing parameters.
// Assumes a data width of whole bytes and pins sampled by the memory
// asynchronously; all pin levels are decoded from registered state.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int CLK_NS = 20,
    parameter int T_WP   = 55,
    parameter int T_WC   = 85,
    parameter int T_RC   = 85,
    parameter int T_AA   = 85,
    parameter int T_HZ   = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW/8-1:0] req_mask,
    output logic          req_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          sram_cs_n,
    output logic          sram_we_n,
    output logic          sram_oe_n,
    output logic [DW/8-1:0] sram_be_n,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_dq_out,
    output logic          sram_dq_oe,
    input  logic [DW-1:0] sram_dq_in
);

    localparam int NB      = DW / 8;
    localparam int WP_CYC  = cycles_for(T_WP, CLK_NS);
    localparam int WC_CYC  = cycles_for(T_WC, CLK_NS);
    localparam int REC_CYC = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
    localparam int RC_CYC  = cycles_for(T_RC, CLK_NS);
    localparam int AA_CYC  = cycles_for(T_AA, CLK_NS);
    localparam int ACC_CYC = (RC_CYC > AA_CYC) ? RC_CYC : AA_CYC;
    localparam int HZ_CYC  = cycles_for(T_HZ, CLK_NS);
    localparam int MAX_W   = (WP_CYC > REC_CYC) ? WP_CYC : REC_CYC;
    localparam int MAX_R   = (ACC_CYC > HZ_CYC) ? ACC_CYC : HZ_CYC;
    localparam int MAX_C   = (MAX_W > MAX_R) ? MAX_W : MAX_R;
    localparam int CW      = $clog2(MAX_C + 1);

    phase_e        phase;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          phase_last;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;
    logic [NB-1:0] lat_mask;
    logic          strobing;

    sram_ctl_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (phase_last)
    );

    sram_ctl_seq #(
        .AW(AW), .DW(DW), .NB(NB), .CW(CW),
        .WP_CYC(WP_CYC), .REC_CYC(REC_CYC), .ACC_CYC(ACC_CYC), .HZ_CYC(HZ_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_mask   (req_mask),
        .phase_last (phase_last),
        .phase      (phase),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .lat_addr   (lat_addr),
        .lat_wdata  (lat_wdata),
        .lat_mask   (lat_mask)
    );

    sram_ctl_capture #(.DW(DW), .NB(NB)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   ((phase == PH_RACC) && phase_last),
        .mask     (lat_mask),
        .data_in  (sram_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // Decode memory pin levels from the current phase.
    always_comb begin
        strobing    = (phase == PH_WPULSE) || (phase == PH_RACC);
        sram_cs_n   = !strobing;
        sram_we_n   = (phase != PH_WPULSE);
        sram_oe_n   = (phase != PH_RACC);
        sram_be_n   = strobing ? ~lat_mask : '1;
        sram_dq_oe  = (phase == PH_WPULSE);
        sram_dq_out = lat_wdata;
        sram_addr   = lat_addr;
        req_ready   = (phase == PH_IDLE);
    end

endmodule

// File: rtl/sram_ctl_chk.sv
// Protocol checker for sram_ctl, attached by bind. Watches pins only.
module sram_ctl_chk #(
    parameter int AW     = 16,
    parameter int WP_CYC = 3,
    parameter int HZ_CYC = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sram_cs_n,
    input logic          sram_we_n,
    input logic          sram_oe_n,
    input logic [AW-1:0] sram_addr,
    input logic          sram_dq_oe,
    input logic          req_ready,
    input logic          rd_valid
);

    logic [31:0] low_run;
    logic [31:0] rd_gap;

    // Length of the current write-enable low run.
    always_ff @(posedge clk) begin
        if (!rst_n)          low_run <= '0;
        else if (!sram_we_n) low_run <= (low_run < 32'd1000) ? low_run + 32'd1 : low_run;
        else                 low_run <= '0;
    end

    // Cycles since output enable was last low.
    always_ff @(posedge clk) begin
        if (!rst_n)          rd_gap <= 32'd1000;
        else if (!sram_oe_n) rd_gap <= '0;
        else if (rd_gap < 32'd1000) rd_gap <= rd_gap + 32'd1;
    end

    // R2
    wr_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n);
    // R2
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && !sram_cs_n) |-> sram_dq_oe);
    // R2
    wp_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sram_we_n) && low_run != 0) |-> (low_run >= 32'(WP_CYC)));
    // R5
    rd_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> !sram_dq_oe);
    // R7
    turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (rd_gap >= 32'(HZ_CYC)));
    // R6
    rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_cs_n |-> !req_ready);
    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW), .WP_CYC(WP_CYC), .HZ_CYC(HZ_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sram_cs_n  (sram_cs_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_addr  (sram_addr),
    .sram_dq_oe (sram_dq_oe),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid)
);

// File: tb/sram_ctl_bench.sv
// Bench for sram_ctl: pin-level memory model plus per-cycle expectations.
module sram_ctl_bench;

    localparam int CLK_NS = 20;
    localparam int T_WP = 55, T_WC = 85, T_RC = 85, T_AA = 85, T_HZ = 30;
    localparam int WPC  = (T_WP + CLK_NS - 1) / CLK_NS;
    localparam int WCC  = (T_WC + CLK_NS - 1) / CLK_NS;
    localparam int RECC = (WCC > WPC) ? WCC - WPC : 1;
    localparam int RCC  = (T_RC + CLK_NS - 1) / CLK_NS;
    localparam int AAC  = (T_AA + CLK_NS - 1) / CLK_NS;
    localparam int ACCC = (RCC > AAC) ? RCC : AAC;
    localparam int HZC  = (T_HZ + CLK_NS - 1) / CLK_NS;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [15:0] req_addr, req_wdata;
    logic [1:0]  req_mask;
    logic        req_ready, rd_valid;
    logic [15:0] rd_data;
    logic        sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [1:0]  sram_be_n;
    logic [15:0] sram_addr, sram_dq_out, sram_dq_in;
    logic [7:0]  pv;

    int checks = 0;
    int errors = 0;
    logic [15:0] dev     [0:63];
    logic [15:0] exp_mem [0:63];

    always #10 clk = ~clk;

    sram_ctl #(.CLK_NS(CLK_NS), .T_WP(T_WP), .T_WC(T_WC), .T_RC(T_RC),
               .T_AA(T_AA), .T_HZ(T_HZ)) u_sram_ctl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_be_n(sram_be_n), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    assign pv = {sram_cs_n, sram_we_n, sram_oe_n, sram_be_n, sram_dq_oe, req_ready, rd_valid};

    // Memory model: writes lanes while selected; unselected read lanes give junk.
    always @(posedge clk) begin
        if (!sram_cs_n && !sram_we_n) begin
            if (!sram_be_n[0]) dev[sram_addr[5:0]][7:0]  <= sram_dq_out[7:0];
            if (!sram_be_n[1]) dev[sram_addr[5:0]][15:8] <= sram_dq_out[15:8];
        end
    end
    always_comb begin
        sram_dq_in[7:0]  = (!sram_cs_n && !sram_oe_n && sram_we_n && !sram_be_n[0])
                           ? dev[sram_addr[5:0]][7:0]  : 8'h5A;
        sram_dq_in[15:8] = (!sram_cs_n && !sram_oe_n && sram_we_n && !sram_be_n[1])
                           ? dev[sram_addr[5:0]][15:8] : 8'hC3;
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle_chk(input string tag);
        chk(tag, pv, {3'b111, 2'b11, 1'b0, 1'b1, 1'b0});
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_mask = m;
        idle_chk("R8 ready before write accept");
        @(negedge clk);
        req_addr = ~a; req_wdata = ~d; req_mask = ~m;  // busy-time junk
        for (int k = 0; k < WPC; k++) begin
            if (k > 0) @(negedge clk);
            chk("R2 R4 R10 write pulse pins", pv, {1'b0, 1'b0, 1'b1, ~m, 1'b1, 1'b0, 1'b0});
            chk("R2 R8 write address", sram_addr, a);
            chk("R2 R8 write data", sram_dq_out, d);
        end
        for (int k = 0; k < RECC; k++) begin
            @(negedge clk);
            chk("R3 write recovery pins", pv, {3'b111, 2'b11, 1'b0, 1'b0, 1'b0});
        end
        @(negedge clk);
        idle_chk("R3 R9 idle after write");
        for (int i = 0; i < 2; i++)
            if (m[i]) exp_mem[a[5:0]][i*8 +: 8] = d[i*8 +: 8];
        req_valid = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, input logic [1:0] m);
        logic [15:0] e;
        e = exp_mem[a[5:0]] & {{8{m[1]}}, {8{m[0]}}};
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 16'h0; req_mask = m;
        idle_chk("R8 ready before read accept");
        @(negedge clk);
        req_addr = ~a; req_mask = ~m; req_write = 1'b1;  // busy-time junk
        for (int k = 0; k < ACCC; k++) begin
            if (k > 0) @(negedge clk);
            chk("R5 R4 R10 read access pins", pv, {1'b0, 1'b1, 1'b0, ~m, 1'b0, 1'b0, 1'b0});
            chk("R5 R8 read address", sram_addr, a);
        end
        @(negedge clk);
        chk("R6 R7 valid pulse pins", pv, {3'b111, 2'b11, 1'b0, 1'b0, 1'b1});
        chk("R6 read data", rd_data, e);
        for (int k = 1; k < HZC; k++) begin
            @(negedge clk);
            chk("R7 turnaround pins", pv, {3'b111, 2'b11, 1'b0, 1'b0, 1'b0});
        end
        @(negedge clk);
        idle_chk("R7 R9 idle after turnaround");
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #(200000 * 20);
        checks++; errors++;
        $display("FAIL R9 watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin dev[i] = 16'h0; exp_mem[i] = 16'h0; end
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; req_mask = '0;
        repeat (3) @(negedge clk);
        idle_chk("R1 pins during reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_chk("R1 pins after reset");

        do_write(16'h0000, 16'h1234, 2'b11);
        do_read (16'h0000, 2'b11);
        do_write(16'h0001, 16'hABCD, 2'b01);
        do_read (16'h0001, 2'b11);
        do_write(16'hFFFF, 16'h5678, 2'b10);
        do_read (16'hFFFF, 2'b10);
        do_read (16'hFFFF, 2'b01);
        do_write(16'h0002, 16'h9999, 2'b00);   // R4: no lane written
        do_read (16'h0002, 2'b11);
        do_write(16'h0000, 16'hBEEF, 2'b11);   // write straight after read (R7)
        do_write(16'h0001, 16'h7700, 2'b10);   // back-to-back writes (R9)
        do_read (16'h0000, 2'b11);
        do_read (16'h0001, 2'b11);             // back-to-back reads
        do_read (16'h0002, 2'b00);

        // R11: reset in the middle of a write pulse.
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0007;
        req_wdata = 16'h4242; req_mask = 2'b11;
        @(negedge clk);
        chk("R11 pulse started", pv, {1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0});
        rst_n = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        idle_chk("R11 R1 idle after mid-access reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_chk("R11 idle after release");
        do_read(16'h0000, 2'b11);

        finish_run();
    end

endmodule